// File: doc/BRIEF.md
# ARP Address Cache and Resolver

This block turns destination IPv4 addresses into Ethernet MAC addresses for a hardware UDP transmit path. A send path asks for a destination over a lookup port and gets back a single-cycle response. The response carries either the MAC address or a failure code. The block keeps a table of address pairs for hosts on the local subnet. The table is filled from ARP traffic that a frame parser has already decoded and hands in over a receive port.

When a lookup misses, the block asks for an ARP request frame on its transmit-request port. It then waits a set number of cycles for the answer. It asks again up to a set retry count, and after that it reports the destination as unreachable. The block also answers ARP requests that ask for the local address, and it learns from every on-subnet sender it sees. Replies leave the transmit-request port ahead of queued requests. The frame builder downstream gives this port precedence over bulk user data.

Top module: `arp_resolver`

## Requirements
- R1: After reset, `lk_ready` is 1, `rsp_valid` is 0, `tx_valid` is 0, and the table holds no entries.
- R2: A lookup is accepted on a cycle with `lk_valid` and `lk_ready` both high. If `(lk_ip & netmask) != (local_ip & netmask)`, `rsp_valid` is high on the next cycle with `rsp_status` = 1 (off-subnet) and `rsp_mac` = 0. No ARP request is made.
- R3: When an accepted on-subnet lookup finds its address in the table, `rsp_valid` is high two cycles after acceptance with `rsp_status` = 0 (resolved) and the stored MAC.
- R4: The table slot is chosen by the low 8 bits of the IP address, and the full address is compared on a lookup. A different address that shares the slot counts as a miss. A later learn for that slot overwrites the entry.
- R5: On a miss, an ARP request is presented with `tx_is_reply` = 0, `tx_tpa` = the looked-up address and `tx_tha` = 0.
- R6: While a miss is pending, a learnable ARP packet whose sender address equals the pending destination ends the lookup. The response has status 0 and the MAC from that packet.
- R7: After each request is accepted on the transmit port, the block waits `TIMEOUT` cycles and then re-requests, up to `MAX_RETRY` (3) times. With no answer, 1 + `MAX_RETRY` requests are sent, and then the response reports `rsp_status` = 2 (unreachable).
- R8: A received ARP request (`rx_is_req` = 1) with an on-subnet sender and `rx_tpa` = `local_ip` produces a reply with `tx_is_reply` = 1, `tx_tha` = `rx_sha` and `tx_tpa` = `rx_spa`. Other requests produce no frame.
- R9: Received replies and received requests both write `rx_spa` → `rx_sha` into the table, but only when the sender is on the subnet. Packets from off-subnet senders change nothing.
- R10: When both kinds of frame are queued, a pending reply is issued before a pending request. While `tx_valid` is high and `tx_ready` is low, the presented frame stays unchanged.
- R11: `rsp_valid` lasts one cycle, and `lk_ready` is low from acceptance until the response cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_ip | input | 32 | Own IPv4 address |
| netmask | input | 32 | Subnet mask |
| lk_valid | input | 1 | Lookup request valid |
| lk_ip | input | 32 | Destination address to resolve |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Lookup response pulse |
| rsp_status | output | 2 | 0 resolved, 1 off-subnet, 2 unreachable |
| rsp_mac | output | 48 | Resolved MAC address |
| rx_valid | input | 1 | Parsed ARP packet valid |
| rx_is_req | input | 1 | 1 for a request, 0 for a reply |
| rx_sha | input | 48 | Sender MAC of the packet |
| rx_spa | input | 32 | Sender IP of the packet |
| rx_tpa | input | 32 | Target IP of the packet |
| tx_valid | output | 1 | ARP frame request valid |
| tx_ready | input | 1 | Frame builder accepts the request |
| tx_is_reply | output | 1 | 1 for a reply, 0 for a request |
| tx_tha | output | 48 | Target MAC for the frame (0 in requests) |
| tx_tpa | output | 32 | Target IP for the frame |

## Verification
Lookups are tried against several kinds of table state. Addresses learned from replies and from requests should both resolve, which shows both learning sources work. Off-subnet addresses separate the early reject from a table miss. An address that shares a slot with a stored one but differs in its upper bits catches a design that compares only the index. The miss path is run once with a reply arriving during the wait and once with silence, which separates a learned finish from the counted retries and the final unreachable code. Held-off transmit traffic shows whether replies overtake queued requests.

// File: rtl/arp_pkg.sv
package arp_pkg;
  localparam int IP_W  = 32;
  localparam int MAC_W = 48;

  typedef enum logic [1:0] {
    LK_RESOLVED = 2'd0,
    LK_OFFNET   = 2'd1,
    LK_UNREACH  = 2'd2
  } lk_status_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_LOOK = 2'd1,
    FSM_WAIT = 2'd2
  } rslv_state_e;

  function automatic logic on_net(input logic [IP_W-1:0] a, input logic [IP_W-1:0] b,
                                  input logic [IP_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction
endpackage

// File: rtl/arp_table.sv
module arp_table #(
  parameter int IDX_W = 8,
  parameter int IP_W  = 32,
  parameter int MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IP_W-1:0]  wr_ip,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic             rd_en,
  input  logic [IP_W-1:0]  rd_ip,
  output logic             rd_hit,
  output logic [MAC_W-1:0] rd_mac
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ROW_W = IP_W + MAC_W;

  logic [ROW_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] used;
  logic [ROW_W-1:0] row_q;
  logic             used_q;
  logic [IP_W-1:0]  key_q;

  // Payload array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ip[IDX_W-1:0]] <= {wr_ip, wr_mac};
    if (rd_en) begin
      row_q <= mem[rd_ip[IDX_W-1:0]];
      key_q <= rd_ip;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used   <= '0;
      used_q <= 1'b0;
    end else begin
      if (wr_en) used[wr_ip[IDX_W-1:0]] <= 1'b1;
      if (rd_en) used_q <= used[rd_ip[IDX_W-1:0]];
    end
  end

  assign rd_hit = used_q && (row_q[ROW_W-1:MAC_W] == key_q);
  assign rd_mac = row_q[MAC_W-1:0];
endmodule

// File: rtl/arp_tx_arb.sv
module arp_tx_arb #(
  parameter int IP_W  = 32,
  parameter int MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rep_set,
  input  logic [MAC_W-1:0] rep_mac,
  input  logic [IP_W-1:0]  rep_ip,
  input  logic             req_set,
  input  logic [IP_W-1:0]  req_ip,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_is_reply,
  output logic [MAC_W-1:0] tx_tha,
  output logic [IP_W-1:0]  tx_tpa,
  output logic             req_sent
);
  logic             rp_v, rq_v;
  logic [MAC_W-1:0] rp_mac;
  logic [IP_W-1:0]  rp_ip, rq_ip;
  logic             load;

  assign load     = !tx_valid || tx_ready;
  assign req_sent = tx_valid && tx_ready && !tx_is_reply;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_v        <= 1'b0;
      rq_v        <= 1'b0;
      rp_mac      <= '0;
      rp_ip       <= '0;
      rq_ip       <= '0;
      tx_valid    <= 1'b0;
      tx_is_reply <= 1'b0;
      tx_tha      <= '0;
      tx_tpa      <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (load && rp_v) begin
        tx_valid    <= 1'b1;
        tx_is_reply <= 1'b1;
        tx_tha      <= rp_mac;
        tx_tpa      <= rp_ip;
        rp_v        <= 1'b0;
      end else if (load && rq_v) begin
        tx_valid    <= 1'b1;
        tx_is_reply <= 1'b0;
        tx_tha      <= '0;
        tx_tpa      <= rq_ip;
        rq_v        <= 1'b0;
      end
      if (rep_set) begin
        rp_v   <= 1'b1;
        rp_mac <= rep_mac;
        rp_ip  <= rep_ip;
      end
      if (req_set) begin
        rq_v  <= 1'b1;
        rq_ip <= req_ip;
      end
    end
  end
endmodule

// File: rtl/arp_resolver.sv
module arp_resolver #(
  parameter int IDX_W     = 8,
  parameter int TIMEOUT   = 125000,
  parameter int MAX_RETRY = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] local_ip,
  input  logic [31:0] netmask,
  input  logic        lk_valid,
  input  logic [31:0] lk_ip,
  output logic        lk_ready,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [47:0] rsp_mac,
  input  logic        rx_valid,
  input  logic        rx_is_req,
  input  logic [47:0] rx_sha,
  input  logic [31:0] rx_spa,
  input  logic [31:0] rx_tpa,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_is_reply,
  output logic [47:0] tx_tha,
  output logic [31:0] tx_tpa
);
  import arp_pkg::*;

  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam int TRY_W = $clog2(MAX_RETRY + 1);

  rslv_state_e        state;
  logic [IP_W-1:0]    tgt_ip;
  logic [TMR_W-1:0]   timer;
  logic [TRY_W-1:0]   tries;
  logic               pend;
  logic               tbl_hit;
  logic [MAC_W-1:0]   tbl_mac;
  logic               learn, answer, rx_tgt, tmo, req_set, req_sent, accept;

  assign learn    = rx_valid && on_net(rx_spa, local_ip, netmask);
  assign answer   = learn && rx_is_req && (rx_tpa == local_ip);
  assign rx_tgt   = learn && (rx_spa == tgt_ip);
  assign lk_ready = (state == FSM_IDLE) && !rsp_valid;
  assign accept   = lk_valid && lk_ready;
  assign tmo      = !pend && (timer == TMR_W'(TIMEOUT - 1));
  assign req_set  = ((state == FSM_LOOK) && !tbl_hit && !rx_tgt) ||
                    ((state == FSM_WAIT) && !rx_tgt && tmo && (tries != TRY_W'(MAX_RETRY)));

  arp_table #(.IDX_W(IDX_W), .IP_W(IP_W), .MAC_W(MAC_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(learn), .wr_ip(rx_spa), .wr_mac(rx_sha),
    .rd_en(accept), .rd_ip(lk_ip),
    .rd_hit(tbl_hit), .rd_mac(tbl_mac)
  );

  arp_tx_arb #(.IP_W(IP_W), .MAC_W(MAC_W)) u_arb (
    .clk(clk), .rst(rst),
    .rep_set(answer), .rep_mac(rx_sha), .rep_ip(rx_spa),
    .req_set(req_set), .req_ip(tgt_ip),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_is_reply(tx_is_reply),
    .tx_tha(tx_tha), .tx_tpa(tx_tpa), .req_sent(req_sent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FSM_IDLE;
      tgt_ip     <= '0;
      timer      <= '0;
      tries      <= '0;
      pend       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_mac    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        FSM_IDLE: if (accept) begin
          tgt_ip <= lk_ip;
          if (!on_net(lk_ip, local_ip, netmask)) begin
            rsp_valid  <= 1'b1;
            rsp_status <= LK_OFFNET;
            rsp_mac    <= '0;
          end else begin
            state <= FSM_LOOK;
          end
        end
        FSM_LOOK: begin
          if (tbl_hit || rx_tgt) begin
            rsp_valid  <= 1'b1;
            rsp_status <= LK_RESOLVED;
            rsp_mac    <= tbl_hit ? tbl_mac : rx_sha;
            state      <= FSM_IDLE;
          end else begin
            tries <= '0;
            timer <= '0;
            pend  <= 1'b1;
            state <= FSM_WAIT;
          end
        end
        FSM_WAIT: begin
          if (rx_tgt) begin
            rsp_valid  <= 1'b1;
            rsp_status <= LK_RESOLVED;
            rsp_mac    <= rx_sha;
            pend       <= 1'b0;
            state      <= FSM_IDLE;
          end else if (req_sent) begin
            pend  <= 1'b0;
            timer <= '0;
          end else if (tmo) begin
            if (tries == TRY_W'(MAX_RETRY)) begin
              rsp_valid  <= 1'b1;
              rsp_status <= LK_UNREACH;
              rsp_mac    <= '0;
              state      <= FSM_IDLE;
            end else begin
              tries <= tries + 1'b1;
              timer <= '0;
              pend  <= 1'b1;
            end
          end else if (!pend) begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= FSM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arp_resolver_chk.sv
module arp_resolver_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] local_ip,
  input logic [31:0] netmask,
  input logic        lk_valid,
  input logic [31:0] lk_ip,
  input logic        lk_ready,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [47:0] rsp_mac,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_is_reply,
  input logic [47:0] tx_tha,
  input logic [31:0] tx_tpa
);
  assert_offnet_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && (((lk_ip ^ local_ip) & netmask) != 0))
      |=> (rsp_valid && rsp_status == 2'd1 && rsp_mac == 48'd0));

  assert_req_tha_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_is_reply) |-> (tx_tha == 48'd0));

  assert_reply_net_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_is_reply) |-> (((tx_tpa ^ local_ip) & netmask) == 0));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready)
      |=> (tx_valid && $stable(tx_is_reply) && $stable(tx_tpa) && $stable(tx_tha)));

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !lk_ready);

  assert_status_code_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'd3));
endmodule

bind arp_resolver arp_resolver_chk u_chk (.*);

// File: tb/arp_resolver_tb.sv
module arp_resolver_tb;
  localparam int TMO = 20;
  localparam logic [31:0] MY_IP = 32'hC0A8_010A;
  localparam logic [31:0] MASK  = 32'hFFFF_0000;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, rx_valid = 0, rx_is_req = 0, tx_ready = 1;
  logic [31:0] lk_ip = 0, rx_spa = 0, rx_tpa = 0;
  logic [47:0] rx_sha = 0;
  logic lk_ready, rsp_valid, tx_valid, tx_is_reply;
  logic [1:0] rsp_status;
  logic [47:0] rsp_mac, tx_tha;
  logic [31:0] tx_tpa;

  always #2 clk = ~clk;

  arp_resolver #(.IDX_W(8), .TIMEOUT(TMO), .MAX_RETRY(3)) u_dut (
    .clk(clk), .rst(rst), .local_ip(MY_IP), .netmask(MASK),
    .lk_valid(lk_valid), .lk_ip(lk_ip), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_mac(rsp_mac),
    .rx_valid(rx_valid), .rx_is_req(rx_is_req), .rx_sha(rx_sha),
    .rx_spa(rx_spa), .rx_tpa(rx_tpa),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_is_reply(tx_is_reply),
    .tx_tha(tx_tha), .tx_tpa(tx_tpa)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int n_tx = 0;
  logic        log_rep [64];
  logic [31:0] log_tpa [64];
  logic [47:0] log_tha [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && tx_valid && tx_ready && n_tx < 64) begin
      log_rep[n_tx] <= tx_is_reply;
      log_tpa[n_tx] <= tx_tpa;
      log_tha[n_tx] <= tx_tha;
      n_tx <= n_tx + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic isreq, input logic [47:0] sha,
                         input logic [31:0] spa, input logic [31:0] tpa);
    @(negedge clk);
    rx_valid = 1; rx_is_req = isreq; rx_sha = sha; rx_spa = spa; rx_tpa = tpa;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic start_lookup(input logic [31:0] ip);
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1; lk_ip = ip;
    @(negedge clk);
    lk_valid = 0;
  endtask

  // Called right after start_lookup: now one cycle after acceptance.
  task automatic wait_rsp(output int lat, output logic [1:0] st, output logic [47:0] mac);
    lat = 1;
    while (!rsp_valid && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    st = rsp_status; mac = rsp_mac;
  endtask

  typedef struct packed {
    logic [31:0] ip;
    logic [1:0]  st;
    logic [47:0] mac;
    int          lat;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{32'hC0A8_0101, 2'd0, 48'hA0_00_00_00_00_01, 2},
    '{32'hC0A8_0102, 2'd0, 48'hA0_00_00_00_00_02, 2},
    '{32'hC0A8_0103, 2'd0, 48'hA0_00_00_00_00_03, 2},
    '{32'hC0A8_0204, 2'd0, 48'hA0_00_00_00_00_04, 2},
    '{32'hC0A8_0105, 2'd0, 48'hB0_00_00_00_00_05, 2},
    '{32'h0A01_0203, 2'd1, 48'h0,                 1},
    '{32'hC0A9_0001, 2'd1, 48'h0,                 1}
  };

  initial begin
    int lat; logic [1:0] st; logic [47:0] mac; int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 lk_ready", 64'(lk_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 tx_valid", 64'(tx_valid), 64'd0);

    // R9 fill: four from replies, one from a request not aimed at us
    send_rx(0, 48'hA0_00_00_00_00_01, 32'hC0A8_0101, MY_IP);
    send_rx(0, 48'hA0_00_00_00_00_02, 32'hC0A8_0102, MY_IP);
    send_rx(0, 48'hA0_00_00_00_00_03, 32'hC0A8_0103, MY_IP);
    send_rx(0, 48'hA0_00_00_00_00_04, 32'hC0A8_0204, MY_IP);
    send_rx(1, 48'hB0_00_00_00_00_05, 32'hC0A8_0105, 32'hC0A8_01FE);
    // R9 off-subnet sender must not overwrite slot 0x01
    send_rx(0, 48'hEE_EE_EE_EE_EE_EE, 32'h0A00_0001, MY_IP);
    repeat (2) @(negedge clk);
    check("R8 no reply to foreign target", 64'(n_tx), 64'd0);

    // R2 R3 R9 vector walk
    base = n_tx;
    foreach (VEC[i]) begin
      start_lookup(VEC[i].ip);
      wait_rsp(lat, st, mac);
      check(VEC[i].st == 2'd0 ? "R3 status" : "R2 status", 64'(st), 64'(VEC[i].st));
      check(VEC[i].st == 2'd0 ? "R3 mac" : "R2 mac", 64'(mac), 64'(VEC[i].mac));
      check(VEC[i].st == 2'd0 ? "R3 latency" : "R2 latency", 64'(lat), 64'(VEC[i].lat));
      @(negedge clk);
      check("R11 pulse", 64'(rsp_valid), 64'd0);
    end
    check("R2 no request for hits/offnet", 64'(n_tx - base), 64'd0);

    // R4 R5 R6: same slot as 192.168.1.4? no: 192.168.1.4 differs from stored .2.4
    base = n_tx;
    start_lookup(32'hC0A8_0104);
    while (n_tx == base) @(negedge clk);
    check("R5 request kind", 64'(log_rep[base]), 64'd0);
    check("R5 request tpa", 64'(log_tpa[base]), 64'hC0A8_0104);
    check("R5 request tha", 64'(log_tha[base]), 64'd0);
    check("R11 busy while pending", 64'(lk_ready), 64'd0);
    send_rx(0, 48'hC0_00_00_00_00_04, 32'hC0A8_0104, MY_IP);
    wait_rsp(lat, st, mac);
    check("R6 status", 64'(st), 64'd0);
    check("R6 mac", 64'(mac), 64'hC0_00_00_00_00_04);

    // R4 overwrite: old 192.168.2.4 now gone; R7 times out after 4 requests
    @(negedge clk);
    base = n_tx;
    start_lookup(32'hC0A8_0204);
    wait_rsp(lat, st, mac);
    check("R7 unreachable", 64'(st), 64'd2);
    check("R7 request count", 64'(n_tx - base), 64'd4);
    check("R4 overwritten slot requested", 64'(log_tpa[base]), 64'hC0A8_0204);
    check("R7 wait length", 64'(lat >= 4 * TMO), 64'd1);

    // R8 answer, off-subnet asker ignored
    @(negedge clk);
    base = n_tx;
    send_rx(1, 48'hDD_00_00_00_00_09, 32'hC0A8_0109, MY_IP);
    send_rx(1, 48'hDD_00_00_00_00_0A, 32'h0B00_0009, MY_IP);
    repeat (4) @(negedge clk);
    check("R8 one reply", 64'(n_tx - base), 64'd1);
    check("R8 reply kind", 64'(log_rep[base]), 64'd1);
    check("R8 reply tha", 64'(log_tha[base]), 64'hDD_00_00_00_00_09);
    check("R8 reply tpa", 64'(log_tpa[base]), 64'hC0A8_0109);

    // R10 priority: stall, queue request then two replies
    tx_ready = 0;
    base = n_tx;
    send_rx(1, 48'hDD_00_00_00_00_11, 32'hC0A8_0111, MY_IP);
    start_lookup(32'hC0A8_0177);
    repeat (3) @(negedge clk);
    send_rx(1, 48'hDD_00_00_00_00_12, 32'hC0A8_0112, MY_IP);
    @(negedge clk);
    check("R10 held frame", 64'(tx_tpa), 64'hC0A8_0111);
    tx_ready = 1;
    repeat (4) @(negedge clk);
    check("R10 first", 64'(log_tpa[base]), 64'hC0A8_0111);
    check("R10 reply before request", 64'(log_tpa[base+1]), 64'hC0A8_0112);
    check("R10 request last", 64'(log_tpa[base+2]), 64'hC0A8_0177);
    send_rx(0, 48'hC0_00_00_00_01_77, 32'hC0A8_0177, MY_IP);
    wait_rsp(lat, st, mac);
    check("R6 resolved after stall", 64'(mac), 64'hC0_00_00_00_01_77);

    // R9 slot 0x01 still holds the on-subnet entry
    @(negedge clk);
    start_lookup(32'hC0A8_0101);
    wait_rsp(lat, st, mac);
    check("R9 off-subnet ignored", 64'(mac), 64'hA0_00_00_00_00_01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule